// File: doc/BRIEF.md
# Raster Timing Generator with Variable Vertical Total

This block produces the horizontal and vertical raster timing for one display pipe. A pixel counter and a line counter run from programmed totals. The counter origin sits at the start of sync. Blank, sync and vertical-interrupt windows are decoded from the two counters. The live position and a frame count can be read back at any time.

The vertical total is either fixed or stretchable, which supports a dynamic refresh rate. In stretchable mode a frame may end on any line between a programmed minimum and maximum. An input from the content source decides where it ends. An external trigger can force both counters back to the origin, so that a slave display locks to a master's vertical sync. The trigger edge follows the vertical-sync polarity, and a sticky flag records that a forced reset took place.

Software programs the block through a simple write port and a combinational read port. Timing fields are double-buffered: a write lands in a pending copy, and that copy becomes active at the next frame start. The control word is the exception and takes effect at once. A combinational check on the pending values reports whether the programmed timing meets the minimum blank and sync sizes.

Top module: `rtg_top`

## Requirements
- R1: Counting and sync.
  - While run (control bit 0 at address 0xA) is set, the pixel count steps 0..Ht, where Ht is the pixel total minus one at address 0x0. At the end of each line the line count advances.
  - `hsync_o` is high while the pixel count is below the width at 0x3.
  - `vsync_o` equals (line count below the width at 0x7) XOR the polarity bit (control bit 2).
- R2: Blank windows.
  - `hblank_o` is high when the pixel count is at or above the blank-start value (0x1) or below the blank-end value (0x2).
  - `vblank_o` follows the same rule on the line count, using 0x5 for start and 0x6 for end.
- R3: Frame count and position readback.
  - The frame count rises by one at every frame start while running, whether from a natural wrap or from a trigger.
  - Address 0xD reads {line count in bits 31:16, pixel count in bits 15:0}.
  - Address 0xE reads the frame count.
- R4: Fixed mode.
  - With the variable-total bit (control bit 1) clear, every frame has exactly (value at 0x4)+1 lines.
  - The minimum and maximum registers (0x8, 0x9) have no effect in this mode.
- R5: Variable mode.
  - A frame ends at the end of the first line whose index is at or above the minimum (0x8, stored as lines minus one) while `vrr_release_i` is high.
  - Otherwise the frame ends at the line whose index equals the maximum (0x9, stored as lines minus one).
- R6: Double buffering.
  - Writes to addresses 0x0..0x9 and 0xB read back at once.
  - They reach the counters and decoders only at the next frame start. While run is clear, a frame start happens on every cycle.
- R7: Trigger edge and gating.
  - With trigger enable (control bit 3) set, an edge on `ext_trig_i` sets both counts to 0 on the next cycle. The edge is rising when the polarity bit is 0 and falling when it is 1.
  - The opposite edge, or any edge while trigger enable is clear, has no effect.
- R8: Trigger flag.
  - Bit 0 of address 0xC is set by every accepted trigger.
  - Any write to 0xC clears it. If a trigger and a clearing write arrive in the same cycle, the trigger wins.
- R9: Vertical interrupt.
  - `vint_o` is high on lines from vblank start up to, but not including, vblank start plus the width at 0xB.
  - It never rises while the active vblank start or vblank end is zero.
- R10: Timing check. `cfg_ok_o` is high only when all of these hold for the pending values:
  - horizontal blank (total − (blank start − blank end)) is at least 32 pixels;
  - horizontal sync is at least 8 pixels;
  - vertical sync is at least 1 line;
  - vertical blank, computed the same way, is at least 3 lines.
- R11: Idle. While run is clear, both counts stay at 0 and the frame count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| vrr_release_i | input | 1 | Allows a variable-length frame to end once past its minimum |
| ext_trig_i | input | 1 | External counter-reset trigger |
| hpos_o | output | 12 | Live pixel count |
| vpos_o | output | 12 | Live line count |
| hblank_o | output | 1 | Horizontal blank window |
| vblank_o | output | 1 | Vertical blank window |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, level set by polarity bit |
| vint_o | output | 1 | Vertical interrupt window |
| frame_cnt_o | output | 16 | Frame count |
| cfg_ok_o | output | 1 | Pending timing meets the minimum sizes |

## Verification
The bound checker watches, on every cycle:
- that the pixel count steps by one and stays within the active total;
- that a wrap lands at or past the minimum line;
- that an accepted trigger zeroes both counts and sets the flag;
- that the frame count rises with every frame start;
- that an unarmed interrupt stays low;
- that an idle block holds still.

Only the bench's scenarios can show the properties that span whole frames or depend on the order of register writes. These are the exact frame lengths under different release patterns in fixed and variable mode, the frame at which a pending total takes hold, and which trigger edge each polarity accepts. The pass/fail thresholds of the timing check also need those scenarios.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
package rtg_pkg;
  localparam int unsigned NFIELD = 12;

  localparam logic [3:0] RA_HTOT  = 4'h0;
  localparam logic [3:0] RA_HBS   = 4'h1;
  localparam logic [3:0] RA_HBE   = 4'h2;
  localparam logic [3:0] RA_HSW   = 4'h3;
  localparam logic [3:0] RA_VTOT  = 4'h4;
  localparam logic [3:0] RA_VBS   = 4'h5;
  localparam logic [3:0] RA_VBE   = 4'h6;
  localparam logic [3:0] RA_VSW   = 4'h7;
  localparam logic [3:0] RA_VMIN  = 4'h8;
  localparam logic [3:0] RA_VMAX  = 4'h9;
  localparam logic [3:0] RA_CTRL  = 4'hA;
  localparam logic [3:0] RA_VINTW = 4'hB;
  localparam logic [3:0] RA_STAT  = 4'hC;
  localparam logic [3:0] RA_POS   = 4'hD;
  localparam logic [3:0] RA_FRAME = 4'hE;

  localparam int CB_RUN  = 0;
  localparam int CB_VRR  = 1;
  localparam int CB_VPOL = 2;
  localparam int CB_TRIG = 3;

  // window that wraps through the counter origin: [start, total) U [0, stop)
  function automatic logic in_wrap(input logic [15:0] pos, input logic [15:0] start,
                                   input logic [15:0] stop);
    return (pos >= start) || (pos < stop);
  endfunction

  // window [base, base+len)
  function automatic logic in_span(input logic [15:0] pos, input logic [15:0] base,
                                   input logic [15:0] len);
    return (pos >= base) && (({1'b0, pos} - {1'b0, base}) < {1'b0, len});
  endfunction

  // blank length = total - (blank start - blank end)
  function automatic logic [16:0] blank_len(input logic [15:0] total_m1,
                                            input logic [15:0] bs, input logic [15:0] be);
    return ({1'b0, total_m1} + 17'd1) - ({1'b0, bs} - {1'b0, be});
  endfunction
endpackage

// File: rtl/rtg_regs.sv
`timescale 1ns/1ps
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 32,
  parameter int FW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [3:0]                   wr_addr,
  input  logic [DW-1:0]                wr_data,
  input  logic [3:0]                   rd_addr,
  output logic [DW-1:0]                rd_data,
  input  logic                         load,
  input  logic                         trig_hit,
  input  logic [CW-1:0]                hpos,
  input  logic [CW-1:0]                vpos,
  input  logic [FW-1:0]                fcnt,
  output logic [NFIELD-1:0][CW-1:0]    pend,
  output logic [NFIELD-1:0][CW-1:0]    act,
  output logic                         stat_flag
);
  localparam int POS_V_LSB = 16;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    logic [CW-1:0] p_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  p_q <= '0;
      else if (wr_en && (wr_addr == 4'(i)))        p_q <= wr_data[CW-1:0];
    end
    assign pend[i] = p_q;

    if (i == int'(RA_CTRL)) begin : g_direct
      assign act[i] = p_q;
    end else begin : g_shadow
      logic [CW-1:0] s_q;
      always_ff @(posedge clk) begin
        if (!rst_n)     s_q <= '0;
        else if (load)  s_q <= p_q;
      end
      assign act[i] = s_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                  stat_flag <= 1'b0;
    else if (trig_hit)                           stat_flag <= 1'b1;
    else if (wr_en && (wr_addr == RA_STAT))      stat_flag <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < 4'(NFIELD)) begin
      rd_data[CW-1:0] = pend[rd_addr];
    end else begin
      case (rd_addr)
        RA_STAT:  rd_data[0] = stat_flag;
        RA_POS: begin
          rd_data[CW-1:0]           = hpos;
          rd_data[POS_V_LSB +: CW]  = vpos;
        end
        RA_FRAME: rd_data[FW-1:0] = fcnt;
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtg_trig.sv
`timescale 1ns/1ps
module rtg_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_trig,
  input  logic fall_sel,
  input  logic arm,
  output logic hit
);
  logic prev_q;
  logic rise_ev, fall_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= ext_trig;
  end

  assign rise_ev = ext_trig & ~prev_q;
  assign fall_ev = ~ext_trig & prev_q;
  assign hit     = arm & (fall_sel ? fall_ev : rise_ev);
endmodule

// File: rtl/rtg_counters.sv
`timescale 1ns/1ps
module rtg_counters #(
  parameter int CW = 12,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] htot_m1,
  input  logic [CW-1:0] vmin_m1,
  input  logic [CW-1:0] vmax_m1,
  input  logic          rel_i,
  input  logic          trig_hit,
  output logic [CW-1:0] hpos,
  output logic [CW-1:0] vpos,
  output logic [FW-1:0] fcnt,
  output logic          line_end,
  output logic          frame_wrap,
  output logic          frame_start
);
  logic past_min, at_max;

  assign line_end    = run && (hpos == htot_m1);
  assign past_min    = vpos >= vmin_m1;
  assign at_max      = vpos >= vmax_m1;
  assign frame_wrap  = line_end && past_min && (rel_i || at_max);
  assign frame_start = !run || trig_hit || frame_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hpos <= '0;
      vpos <= '0;
    end else if (!run || trig_hit) begin
      hpos <= '0;
      vpos <= '0;
    end else if (line_end) begin
      hpos <= '0;
      vpos <= frame_wrap ? '0 : vpos + 1'b1;
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              fcnt <= '0;
    else if (run && (trig_hit || frame_wrap)) fcnt <= fcnt + 1'b1;
  end
endmodule

// File: rtl/rtg_decode.sv
`timescale 1ns/1ps
module rtg_decode
  import rtg_pkg::*;
#(
  parameter int CW         = 12,
  parameter int MIN_HBLANK = 32,
  parameter int MIN_HSYNC  = 8,
  parameter int MIN_VSYNC  = 1,
  parameter int MIN_VBLANK = 3
) (
  input  logic [NFIELD-1:0][CW-1:0] act,
  input  logic [NFIELD-1:0][CW-1:0] pend,
  input  logic [CW-1:0]             hpos,
  input  logic [CW-1:0]             vpos,
  input  logic                      vpol,
  output logic                      hblank,
  output logic                      vblank,
  output logic                      hsync,
  output logic                      vsync,
  output logic                      vint,
  output logic                      cfg_ok
);
  logic [16:0] hbl_len, vbl_len;
  logic        vint_armed;

  assign hblank = in_wrap(16'(hpos), 16'(act[RA_HBS]), 16'(act[RA_HBE]));
  assign vblank = in_wrap(16'(vpos), 16'(act[RA_VBS]), 16'(act[RA_VBE]));
  assign hsync  = hpos < act[RA_HSW];
  assign vsync  = (vpos < act[RA_VSW]) ^ vpol;

  assign vint_armed = (act[RA_VBS] != '0) && (act[RA_VBE] != '0);
  assign vint       = vint_armed && in_span(16'(vpos), 16'(act[RA_VBS]), 16'(act[RA_VINTW]));

  assign hbl_len = blank_len(16'(pend[RA_HTOT]), 16'(pend[RA_HBS]), 16'(pend[RA_HBE]));
  assign vbl_len = blank_len(16'(pend[RA_VTOT]), 16'(pend[RA_VBS]), 16'(pend[RA_VBE]));

  assign cfg_ok = (pend[RA_HBS] >= pend[RA_HBE]) && (pend[RA_VBS] >= pend[RA_VBE]) &&
                  (hbl_len >= 17'(MIN_HBLANK)) && (vbl_len >= 17'(MIN_VBLANK)) &&
                  (pend[RA_HSW] >= CW'(MIN_HSYNC)) && (pend[RA_VSW] >= CW'(MIN_VSYNC));
endmodule

// File: rtl/rtg_top.sv
`timescale 1ns/1ps
module rtg_top
  import rtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 32,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          vrr_release_i,
  input  logic          ext_trig_i,
  output logic [CW-1:0] hpos_o,
  output logic [CW-1:0] vpos_o,
  output logic          hblank_o,
  output logic          vblank_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          vint_o,
  output logic [FW-1:0] frame_cnt_o,
  output logic          cfg_ok_o
);
  logic [NFIELD-1:0][CW-1:0] pend_fields, act_fields;
  logic          stat_flag;
  logic          run, vrr_on, vpol, trig_en;
  logic          line_end, frame_wrap, frame_start, trig_hit;
  logic [CW-1:0] act_htot, act_vbs, act_vbe, vmin_eff, vmax_eff;

  assign run      = act_fields[RA_CTRL][CB_RUN];
  assign vrr_on   = act_fields[RA_CTRL][CB_VRR];
  assign vpol     = act_fields[RA_CTRL][CB_VPOL];
  assign trig_en  = act_fields[RA_CTRL][CB_TRIG];
  assign act_htot = act_fields[RA_HTOT];
  assign act_vbs  = act_fields[RA_VBS];
  assign act_vbe  = act_fields[RA_VBE];
  assign vmin_eff = vrr_on ? act_fields[RA_VMIN] : act_fields[RA_VTOT];
  assign vmax_eff = vrr_on ? act_fields[RA_VMAX] : act_fields[RA_VTOT];

  rtg_regs #(.CW(CW), .DW(DW), .FW(FW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .load(frame_start), .trig_hit(trig_hit),
    .hpos(hpos_o), .vpos(vpos_o), .fcnt(frame_cnt_o),
    .pend(pend_fields), .act(act_fields), .stat_flag(stat_flag)
  );

  rtg_trig u_trig (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig_i), .fall_sel(vpol),
    .arm(run && trig_en), .hit(trig_hit)
  );

  rtg_counters #(.CW(CW), .FW(FW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .htot_m1(act_htot),
    .vmin_m1(vmin_eff), .vmax_m1(vmax_eff), .rel_i(vrr_release_i), .trig_hit(trig_hit),
    .hpos(hpos_o), .vpos(vpos_o), .fcnt(frame_cnt_o),
    .line_end(line_end), .frame_wrap(frame_wrap), .frame_start(frame_start)
  );

  rtg_decode #(.CW(CW)) u_dec (
    .act(act_fields), .pend(pend_fields), .hpos(hpos_o), .vpos(vpos_o), .vpol(vpol),
    .hblank(hblank_o), .vblank(vblank_o), .hsync(hsync_o), .vsync(vsync_o),
    .vint(vint_o), .cfg_ok(cfg_ok_o)
  );
endmodule

// File: rtl/rtg_checks.sv
`timescale 1ns/1ps
module rtg_checks #(
  parameter int CW = 12,
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          line_end,
  input logic          frame_wrap,
  input logic          trig_hit,
  input logic          stat_flag,
  input logic          vint,
  input logic [CW-1:0] hpos,
  input logic [CW-1:0] vpos,
  input logic [CW-1:0] htot_m1,
  input logic [CW-1:0] vmin_eff,
  input logic [CW-1:0] vbs,
  input logic [CW-1:0] vbe,
  input logic [FW-1:0] fcnt
);
  // R1
  hpos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !line_end && !trig_hit) |=> (hpos == $past(hpos) + 1'b1));

  // R1
  hpos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hpos <= htot_m1));

  // R5
  wrap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |-> (vpos >= vmin_eff));

  // R7
  trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> (hpos == '0 && vpos == '0));

  // R8
  trig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> stat_flag);

  // R3
  frame_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (frame_wrap || trig_hit)) |=> (fcnt == $past(fcnt) + 1'b1));

  // R9
  vint_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vbs == '0 || vbe == '0) |-> !vint);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hpos == '0 && vpos == '0 && $stable(fcnt)));
endmodule

bind rtg_top rtg_checks #(.CW(CW), .FW(FW)) u_checks (
  .clk(clk), .rst_n(rst_n), .run(run), .line_end(line_end), .frame_wrap(frame_wrap),
  .trig_hit(trig_hit), .stat_flag(stat_flag), .vint(vint_o), .hpos(hpos_o), .vpos(vpos_o),
  .htot_m1(act_htot), .vmin_eff(vmin_eff), .vbs(act_vbs), .vbe(act_vbe), .fcnt(frame_cnt_o)
);

// File: tb/tb_rtg_top.sv
`timescale 1ns/1ps
module tb_rtg_top;
  localparam int HT = 72, VT = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rel = 1'b0;
  logic        trig = 1'b0;
  logic [11:0] hpos, vpos;
  logic        hblank, vblank, hsync, vsync, vint, cfg_ok;
  logic [15:0] fcnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtg_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vrr_release_i(rel), .ext_trig_i(trig),
    .hpos_o(hpos), .vpos_o(vpos), .hblank_o(hblank), .vblank_o(vblank),
    .hsync_o(hsync), .vsync_o(vsync), .vint_o(vint), .frame_cnt_o(fcnt), .cfg_ok_o(cfg_ok)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; trig = 1'b0; rel = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic cfg_base();
    wr(4'h0, 71); wr(4'h1, 60); wr(4'h2, 20); wr(4'h3, 8);
    wr(4'h4, 9);  wr(4'h5, 8);  wr(4'h6, 3);  wr(4'h7, 1);
    wr(4'hB, 2);  wr(4'h8, 0);  wr(4'h9, 0);
  endtask

  // cycles from run until the frame count first changes
  task automatic measure(input int rel_line, output int len);
    len = 0;
    forever begin
      @(negedge clk);
      if (fcnt != 0 || len > 5000) break;
      if (rel_line >= 0 && int'(vpos) == rel_line) rel = 1'b1;
      len++;
    end
  endtask

  task automatic wait_h(input int h);
    do @(negedge clk); while (int'(hpos) != h);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int len;
    int h0;
    bit seen;

    // reset state
    do_reset();
    @(negedge clk);
    chk("R11", "reset hpos", hpos, 0);
    chk("R11", "reset vpos", vpos, 0);
    chk("R3", "reset frame", fcnt, 0);
    rd(4'hC, d); chk("R8", "reset flag", d, 0);
    rd(4'h0, d); chk("R6", "reset htot", d, 0);

    // idle: programmed but not running
    cfg_base();
    repeat (10) @(negedge clk);
    chk("R11", "idle hpos", hpos, 0);
    chk("R11", "idle frame", fcnt, 0);

    // full sweep of two frames in fixed mode
    wr(4'hA, 32'h1);
    for (int n = 0; n < 2 * HT * VT; n++) begin
      int h, v;
      @(negedge clk);
      h = n % HT; v = (n / HT) % VT;
      chk("R1", "hpos", hpos, h);
      chk("R1", "vpos", vpos, v);
      chk("R1", "hsync", hsync, (h < 8) ? 1 : 0);
      chk("R1", "vsync", vsync, (v < 1) ? 1 : 0);
      chk("R2", "hblank", hblank, (h >= 60 || h < 20) ? 1 : 0);
      chk("R2", "vblank", vblank, (v >= 8 || v < 3) ? 1 : 0);
      chk("R9", "vint", vint, (v >= 8 && v < 10) ? 1 : 0);
      chk("R3", "frame", fcnt, n / (HT * VT));
      if (n == 100) begin rd(4'hD, d); chk("R3", "pos read", d, (1 << 16) | 28); end
      if (n == 800) begin rd(4'hE, d); chk("R3", "frame read", d, 1); end
    end

    // fixed mode ignores min/max and release
    do_reset(); cfg_base(); wr(4'h8, 3); wr(4'h9, 20);
    rel = 1'b1; wr(4'hA, 32'h1); measure(-1, len);
    chk("R4", "fixed len rel=1", len, HT * VT);
    do_reset(); cfg_base(); wr(4'h8, 3); wr(4'h9, 20);
    wr(4'hA, 32'h1); measure(-1, len);
    chk("R4", "fixed len rel=0", len, HT * VT);

    // variable mode
    do_reset(); cfg_base(); wr(4'h8, 9); wr(4'h9, 13);
    wr(4'hA, 32'h3); measure(-1, len);
    chk("R5", "vrr held to max", len, HT * 14);
    do_reset(); cfg_base(); wr(4'h8, 9); wr(4'h9, 13);
    rel = 1'b1; wr(4'hA, 32'h3); measure(-1, len);
    chk("R5", "vrr release at min", len, HT * 10);
    do_reset(); cfg_base(); wr(4'h8, 9); wr(4'h9, 13);
    wr(4'hA, 32'h3); measure(11, len);
    chk("R5", "vrr release on line 11", len, HT * 12);

    // double buffering of the pixel total
    do_reset(); cfg_base(); wr(4'hA, 32'h1);
    do @(negedge clk); while (vpos != 2);
    wr(4'h0, 79);
    rd(4'h0, d); chk("R6", "pending readback", d, 79);
    wait_h(71); @(negedge clk);
    chk("R6", "old total this frame", hpos, 0);
    do @(negedge clk); while (fcnt != 1);
    wait_h(71); @(negedge clk);
    chk("R6", "new total next frame", hpos, 72);
    wait_h(79); @(negedge clk);
    chk("R6", "new total wraps", hpos, 0);

    // trigger, rising edge with polarity 0
    do_reset(); cfg_base(); wr(4'hA, 32'h9);
    do @(negedge clk); while (!(vpos == 4 && hpos == 30));
    trig = 1'b1;
    @(negedge clk);
    chk("R7", "rise resets hpos", hpos, 0);
    chk("R7", "rise resets vpos", vpos, 0);
    chk("R3", "trigger frame count", fcnt, 1);
    rd(4'hC, d); chk("R8", "flag set", d, 1);
    @(negedge clk);
    chk("R7", "count resumes", hpos, 1);
    trig = 1'b0;
    @(negedge clk);
    chk("R7", "falling ignored at pol 0", hpos, 2);
    wr(4'hC, 32'h0);
    rd(4'hC, d); chk("R8", "flag cleared", d, 0);

    // trigger, falling edge with polarity 1
    wr(4'hA, 32'hD);
    wait_h(10);
    trig = 1'b1;
    @(negedge clk);
    chk("R7", "rising ignored at pol 1", hpos, 11);
    trig = 1'b0;
    @(negedge clk);
    chk("R7", "fall resets hpos", hpos, 0);
    chk("R7", "fall resets vpos", vpos, 0);
    chk("R1", "vsync inverted in sync", vsync, 0);
    rd(4'hC, d); chk("R8", "flag set on fall", d, 1);
    do @(negedge clk); while (vpos != 2);
    chk("R1", "vsync inverted outside sync", vsync, 1);

    // trigger disabled
    wr(4'hC, 32'h0);
    wr(4'hA, 32'h5);
    wait_h(10);
    h0 = int'(hpos);
    trig = 1'b1; @(negedge clk);
    trig = 1'b0; @(negedge clk);
    chk("R7", "disabled trigger ignored", hpos, h0 + 2);
    rd(4'hC, d); chk("R8", "no flag when disabled", d, 0);

    // interrupt not armed when vblank end is zero
    do_reset(); cfg_base(); wr(4'h6, 0); wr(4'hA, 32'h1);
    seen = 0;
    for (int n = 0; n < HT * VT; n++) begin
      @(negedge clk);
      if (vint) seen = 1;
    end
    chk("R9", "unarmed vint never high", seen, 0);

    // timing check thresholds
    do_reset(); cfg_base();
    chk("R10", "base config ok", cfg_ok, 1);
    wr(4'h3, 7);  chk("R10", "hsync 7", cfg_ok, 0);
    wr(4'h3, 8);  chk("R10", "hsync 8", cfg_ok, 1);
    wr(4'h1, 61); chk("R10", "hblank 31", cfg_ok, 0);
    wr(4'h1, 60); wr(4'h7, 0); chk("R10", "vsync 0", cfg_ok, 0);
    wr(4'h7, 1);  wr(4'h6, 2); wr(4'h5, 10); chk("R10", "vblank 2", cfg_ok, 0);
    wr(4'h6, 3);  chk("R10", "vblank 3", cfg_ok, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule